// File: doc/BRIEF.md
# UART Receive Byte Queue with Watermark Interrupt

This block sits between a UART receiver front end and a processor-style read port. Each deserialized byte arrives with a one-cycle valid strobe and a framing-error flag. The block stores the byte and its flag together in a 32-entry first-in first-out queue. The oldest entry is always visible on the read outputs, and a one-cycle read strobe removes it.

An interrupt request lets software service the queue in batches instead of once per character. Software picks a watermark of one, two, three or four quarters of the depth. A per-byte mode instead raises the request whenever anything is stored, which suits packet traffic where the final byte must not wait. Because a batch watermark can leave the tail of a packet below the threshold, a separate residue flag rises when bytes have been sitting under the watermark and the receiver has been idle for a programmable number of clock cycles. With 8-N-1 framing a character takes ten bit times, so software sets that idle count to a few character times. Status outputs give the fill level, empty, full and a sticky overrun flag.

Top module: `uart_rx_fifo`

## Requirements
- R1: Bytes leave in arrival order. The oldest stored byte and its framing-error bit are shown on `rd_data`/`rd_ferr` while the queue is not empty, and a cycle with `rd_en` high removes that entry.
- R2: `level` gives the stored count from 0 to 32 and is updated on the clock edge after a push or pop. `empty` is high exactly at level 0, and `full` is high exactly at level 32.
- R3: With `cfg_per_byte` low, `irq` is high exactly when level is at or above the threshold. `cfg_thr_sel` encodes the threshold as 0 = 8, 1 = 16, 2 = 24 and 3 = 32. The request drops as soon as reads bring the level below the threshold.
- R4: With `cfg_per_byte` high, `irq` is high exactly when the level is nonzero.
- R5: A change of `cfg_thr_sel` or `cfg_per_byte` is reflected in `irq` by the next clock edge, with the stored data and level unchanged.
- R6: A byte offered while the queue is full and no read happens in the same cycle is discarded. It sets `overrun`, and the stored contents and level stay unchanged.
- R7: `overrun` stays set until a cycle with `ovr_clr` high. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R8: A push and a read in the same cycle at level 32 keep the level at 32, accept the new byte and do not set `overrun`. At level 0, the read is ignored and the byte is stored.
- R9: `rd_en` while the queue is empty has no effect on level or data.
- R10: With `cfg_per_byte` low, `residue` is high when the level is nonzero and below the threshold and at least `cfg_idle_limit` clock edges have passed since the last cycle with `rx_valid` high.
- R11: After reset the queue is empty, and `level`, `irq`, `residue`, `overrun` and `full` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte from the front end |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_ferr | input | 1 | Framing error for the byte on `rx_data` |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Oldest stored byte |
| rd_ferr | output | 1 | Framing-error bit of the oldest entry |
| cfg_thr_sel | input | 2 | Watermark select (0: 8, 1: 16, 2: 24, 3: 32) |
| cfg_per_byte | input | 1 | Interrupt whenever the queue is not empty |
| cfg_idle_limit | input | 16 | Idle clock count before residue is flagged |
| ovr_clr | input | 1 | Write-one-to-clear for `overrun` |
| irq | output | 1 | Level-sensitive interrupt request |
| residue | output | 1 | Bytes sit below the watermark after idle time |
| level | output | 6 | Number of stored entries, 0 to 32 |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level is 32 |
| overrun | output | 1 | Sticky flag for a dropped byte |

## Verification
The assertions assume that `rx_valid` and `rd_en` are clean single-cycle qualifiers sampled on the rising edge, and that the configuration inputs change only between edges. The stimulus changes every input at the falling edge and holds it for a full cycle. It walks every watermark setting across all 33 fill levels, and it presses the full and empty boundaries with pushes and reads in the same cycle. The idle limit is kept small enough that residue timing is observed on both sides of the limit.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    THR_Q1   = 2'd0,
    THR_HALF = 2'd1,
    THR_Q3   = 2'd2,
    THR_ALL  = 2'd3
  } thr_sel_e;

  typedef struct packed {
    logic              ferr;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  rx_entry_t     wr_entry,
  input  logic          rd_req,
  output rx_entry_t     rd_entry,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          ovr_evt
);
  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);

  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          push, pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign pop     = rd_req && !empty;
  assign push    = wr_req && (!full || pop);
  assign ovr_evt = wr_req && full && !pop;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = rd_ptr_q + 1'b1;
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= wr_entry;
  end

  assign rd_entry = mem_q[rd_ptr_q];
  assign level    = cnt_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);                                                   // R2
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));                                                    // R2
  AST_DROP_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !rd_req) |=> (cnt_q == $past(cnt_q)));             // R6
  AST_SWAP_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rd_req && !empty) |=> (cnt_q == $past(cnt_q)));            // R8
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !wr_req) |=> empty);                              // R9
endmodule

// File: rtl/uart_rxq_idle.sv
module uart_rxq_idle #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arrive,
  input  logic [CW-1:0] limit,
  output logic          idle_hit
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (arrive)      cnt_d = '0;
    else if (&cnt_q) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign idle_hit = (cnt_q >= limit);

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    arrive |=> (cnt_q == '0));                                            // R10
endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic [1:0]    thr_sel,
  input  logic          per_byte,
  input  logic          idle_hit,
  output logic          irq,
  output logic          residue
);
  localparam logic [LW-1:0] MARK_Q1   = LW'(DEPTH / 4);
  localparam logic [LW-1:0] MARK_HALF = LW'(DEPTH / 2);
  localparam logic [LW-1:0] MARK_Q3   = LW'((3 * DEPTH) / 4);
  localparam logic [LW-1:0] MARK_ALL  = LW'(DEPTH);

  logic [LW-1:0] mark;
  logic          nonzero, below;

  always_comb begin
    unique case (thr_sel_e'(thr_sel))
      THR_Q1:   mark = MARK_Q1;
      THR_HALF: mark = MARK_HALF;
      THR_Q3:   mark = MARK_Q3;
      default:  mark = MARK_ALL;
    endcase
  end

  assign nonzero = (level != '0);
  assign below   = (level < mark);
  assign irq     = per_byte ? nonzero : !below;
  assign residue = !per_byte && nonzero && below && idle_hit;

  AST_IRQ_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (level == MARK_ALL) |-> irq);                                         // R3
  AST_IRQ_QUIET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !irq);                                              // R4
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int IDLE_W = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_ferr,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_ferr,
  input  logic [1:0]        cfg_thr_sel,
  input  logic              cfg_per_byte,
  input  logic [IDLE_W-1:0] cfg_idle_limit,
  input  logic              ovr_clr,
  output logic              irq,
  output logic              residue,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full,
  output logic              overrun
);
  rx_entry_t wr_entry, rd_entry;
  logic      ovr_evt, idle_hit;
  logic      ovr_q, ovr_d, ovr_en;

  assign wr_entry.data = rx_data;
  assign wr_entry.ferr = rx_ferr;

  uart_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (rx_valid),
    .wr_entry (wr_entry),
    .rd_req   (rd_en),
    .rd_entry (rd_entry),
    .level    (level),
    .empty    (empty),
    .full     (full),
    .ovr_evt  (ovr_evt)
  );

  uart_rxq_idle #(.CW(IDLE_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .arrive   (rx_valid),
    .limit    (cfg_idle_limit),
    .idle_hit (idle_hit)
  );

  uart_rxq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level),
    .thr_sel  (cfg_thr_sel),
    .per_byte (cfg_per_byte),
    .idle_hit (idle_hit),
    .irq      (irq),
    .residue  (residue)
  );

  assign ovr_en = ovr_evt || ovr_clr;
  assign ovr_d  = ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (ovr_en) ovr_q <= ovr_d;
  end

  assign overrun = ovr_q;
  assign rd_data = rd_entry.data;
  assign rd_ferr = rd_entry.ferr;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);                                   // R7
  AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !rd_en) |=> overrun);                            // R6
  AST_PERBYTE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_per_byte && !empty) |-> irq);                                    // R4
  AST_RESIDUE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    residue |-> !empty);                                                  // R10
endmodule

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ferr, rd_en;
  logic [7:0] rd_data;
  logic       rd_ferr;
  logic [1:0] cfg_thr_sel;
  logic       cfg_per_byte;
  logic [15:0] cfg_idle_limit;
  logic       ovr_clr;
  logic       irq, residue, empty, full, overrun;
  logic [5:0] level;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  uart_rx_fifo uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ferr(rx_ferr), .rd_en(rd_en), .rd_data(rd_data), .rd_ferr(rd_ferr),
    .cfg_thr_sel(cfg_thr_sel), .cfg_per_byte(cfg_per_byte),
    .cfg_idle_limit(cfg_idle_limit), .ovr_clr(ovr_clr), .irq(irq),
    .residue(residue), .level(level), .empty(empty), .full(full),
    .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic int mark(input int s);
    return (s + 1) * 8;
  endfunction

  task automatic push(input logic [7:0] d, input logic f);
    rx_data = d; rx_ferr = f; rx_valid = 1'b1;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_data = '0; rx_valid = 1'b0; rx_ferr = 1'b0; rd_en = 1'b0;
    cfg_thr_sel = 2'd0; cfg_per_byte = 1'b0; cfg_idle_limit = 16'hFFFF;
    ovr_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 level", level, 0);
    chk("R11 empty", empty, 1);
    chk("R11 full", full, 0);
    chk("R11 irq", irq, 0);
    chk("R11 residue", residue, 0);
    chk("R11 overrun", overrun, 0);
    rst_n = 1'b1;
    tick();

    // R1 R2 R3 R6 R7 R9 sweep over every watermark and fill level
    for (int s = 0; s < 4; s++) begin
      cfg_thr_sel = 2'(s);
      for (int i = 0; i < 32; i++) begin
        push(pat(s, i), 1'(i ^ s));
        chk("R2 level up", level, i + 1);
        chk("R2 full", full, (i == 31) ? 1 : 0);
        chk("R3 irq fill", irq, (i + 1 >= mark(s)) ? 1 : 0);
      end
      push(8'hEE, 1'b1);
      chk("R6 level kept", level, 32);
      chk("R6 overrun set", overrun, 1);
      for (int i = 0; i < 32; i++) begin
        chk("R1 order", rd_data, pat(s, i));
        chk("R1 ferr", rd_ferr, (i ^ s) & 1);
        pop();
        chk("R2 level down", level, 31 - i);
        chk("R3 irq drain", irq, (31 - i >= mark(s)) ? 1 : 0);
      end
      chk("R6 dropped byte absent", empty, 1);
      chk("R7 overrun sticky", overrun, 1);
      ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
      chk("R7 overrun cleared", overrun, 0);
      pop();
      chk("R9 empty read level", level, 0);
      chk("R9 empty read flag", empty, 1);
    end

    // R4 per-byte mode
    cfg_per_byte = 1'b1;
    cfg_thr_sel = 2'd3;
    tick();
    chk("R4 irq empty", irq, 0);
    push(8'h11, 1'b0);
    chk("R4 irq one byte", irq, 1);
    pop();
    chk("R4 irq drained", irq, 0);
    cfg_per_byte = 1'b0;

    // R5 threshold change without flush
    cfg_thr_sel = 2'd1;
    for (int i = 0; i < 10; i++) push(pat(7, i), 1'b0);
    chk("R5 irq at 16 mark", irq, 0);
    cfg_thr_sel = 2'd0; tick();
    chk("R5 irq after lower mark", irq, 1);
    chk("R5 level intact", level, 10);
    cfg_thr_sel = 2'd3; tick();
    chk("R5 irq after raise", irq, 0);
    cfg_per_byte = 1'b1; tick();
    chk("R5 irq per-byte switch", irq, 1);
    cfg_per_byte = 1'b0;
    chk("R5 data intact", rd_data, pat(7, 0));
    for (int i = 0; i < 10; i++) pop();

    // R7 set wins over clear, R8 full swap
    for (int i = 0; i < 32; i++) push(8'(i), 1'b0);
    ovr_clr = 1'b1;
    push(8'hC3, 1'b0);
    ovr_clr = 1'b0;
    chk("R7 set beats clear", overrun, 1);
    ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
    chk("R7 clear", overrun, 0);
    rx_data = 8'hA5; rx_ferr = 1'b1; rx_valid = 1'b1; rd_en = 1'b1;
    tick();
    rx_valid = 1'b0; rd_en = 1'b0;
    chk("R8 full swap level", level, 32);
    chk("R8 full swap no overrun", overrun, 0);
    chk("R8 full swap head", rd_data, 1);
    for (int i = 0; i < 31; i++) pop();
    chk("R8 swapped byte last", rd_data, 8'hA5);
    chk("R8 swapped ferr", rd_ferr, 1);
    pop();
    rx_data = 8'h5A; rx_ferr = 1'b0; rx_valid = 1'b1; rd_en = 1'b1;
    tick();
    rx_valid = 1'b0; rd_en = 1'b0;
    chk("R8 empty swap level", level, 1);
    chk("R8 empty swap data", rd_data, 8'h5A);
    pop();

    // R10 residue after idle time
    cfg_thr_sel = 2'd0;
    cfg_idle_limit = 16'd5;
    for (int i = 0; i < 3; i++) push(8'(i), 1'b0);
    chk("R10 residue at arrival", residue, 0);
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R10 residue idle", residue, (k >= 5) ? 1 : 0);
    end
    push(8'h33, 1'b0);
    chk("R10 residue restarts", residue, 0);
    repeat (5) tick();
    chk("R10 residue again", residue, 1);
    cfg_per_byte = 1'b1; tick();
    chk("R10 residue off per-byte", residue, 0);
    cfg_per_byte = 1'b0;
    for (int i = 0; i < 5; i++) push(8'(i), 1'b0);
    tick(); tick(); tick(); tick(); tick(); tick();
    chk("R10 residue off at mark", residue, 0);
    chk("R10 irq at mark", irq, 1);
    for (int i = 0; i < 9; i++) pop();
    tick();
    chk("R10 residue empty", residue, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule